// File: doc/BRIEF.md
# Barrel Shifter Operand Stage with Carry

This combinational stage builds the second operand of a 32-bit data-processing operation. It shifts a register value by an amount that comes either from a 5-bit immediate in the instruction or from the low byte of another register. It also derives the shifter carry from the incoming carry flag. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right.

The caller passes instruction bits [11:4] on one port, the operand value, the low byte of the amount register and the current carry flag. The stage returns the shifted operand, the carry-out for the flag logic and a flag that marks a malformed register-amount encoding. Register reads, the adder and flag storage sit outside this stage.

Top module: `shift_operand_unit`

## Requirements
- R1: `field_i` holds instruction bits [11:4]. Bit 0 of the field selects register-amount mode. Bits [2:1] give the kind: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. Bits [7:3] are the immediate amount. `illegal_o` is 1 exactly when bit 0 and bit 3 of the field are both 1; otherwise it is 0.
- R2: In register mode, a `reg_amt_i` of 0 gives `res_o` equal to `val_i` and `carry_o` equal to `carry_i`, whatever the kind.
- R3: In immediate mode, a logical left shift by 0 gives `res_o` equal to `val_i` and `carry_o` equal to `carry_i`.
- R4: For a logical left shift by n, with n from 1 to 31, the result is `val_i << n` and the carry is `val_i[32-n]`. When n is 32, the result is 0 and the carry is `val_i[0]`. When n is above 32, both the result and the carry are 0.
- R5: For a logical right shift, an immediate amount of 0 means 32. For n from 1 to 31, the result is `val_i >> n` and the carry is `val_i[n-1]`. When n is 32 or more, the result is 0 and the carry is `val_i[31]`.
- R6: For an arithmetic right shift, an immediate amount of 0 means 32. For n from 1 to 31, the result is the sign-filled shift and the carry is `val_i[n-1]`. When n is 32 or more, every result bit and the carry equal `val_i[31]`.
- R7: A rotate right by an amount whose value modulo 32 is a nonzero m rotates `val_i` right by m and sets the carry to `val_i[m-1]`.
- R8: A rotate right whose amount modulo 32 is 0 rotates through the carry by one place. This covers immediate 0 and nonzero register amounts 32, 64 and so on. The result is `{carry_i, val_i[31:1]}` and the carry is `val_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| field_i | input | 8 | Instruction bits [11:4]: mode, kind, bit 7 and immediate amount |
| val_i | input | 32 | Operand value to be shifted |
| reg_amt_i | input | 8 | Low byte of the amount register, used in register mode |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |
| illegal_o | output | 1 | Malformed register-amount encoding |

## Verification
The embedded checks act only once every input is known. Before that, a value left floating would make the output unknown rather than wrong. They also assume the stage is sampled after the inputs settle, which holds because the stage keeps no state. The stimulus drives all inputs together before each sample. In register mode it covers every amount from 0 to 255 for each kind. In immediate mode it covers every 5-bit amount. Operand values and carries are random under a fixed seed, and some register-mode cases set bit 7 to raise the illegal flag.

// File: rtl/shift_operand_unit.sv
module shift_operand_unit (
  input  logic [7:0]  field_i,
  input  logic [31:0] val_i,
  input  logic [7:0]  reg_amt_i,
  input  logic        carry_i,
  output logic [31:0] res_o,
  output logic        carry_o,
  output logic        illegal_o
);
  localparam int W = 32;

  typedef enum logic [1:0] {K_LSL, K_LSR, K_ASR, K_ROR} kind_e;

  logic       by_reg;
  kind_e      kind;
  logic [4:0] imm;
  logic [7:0] amt;
  logic       keep;
  logic       big;
  logic [4:0] lo, lo_dec, lo_neg;

  assign by_reg    = field_i[0];
  assign kind      = kind_e'(field_i[2:1]);
  assign imm       = field_i[7:3];
  assign illegal_o = by_reg & field_i[3];

  assign keep   = by_reg ? (reg_amt_i == 8'd0) : (imm == 5'd0 && kind == K_LSL);
  assign amt    = by_reg ? reg_amt_i : ((imm == 5'd0) ? 8'd32 : {3'b000, imm});
  assign big    = amt >= 8'(W);
  assign lo     = amt[4:0];
  assign lo_dec = lo - 5'd1;
  assign lo_neg = 5'd0 - lo;

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (!keep) begin
      unique case (kind)
        K_LSL: begin
          if (!big) begin
            res_o   = val_i << lo;
            carry_o = val_i[lo_neg];
          end else if (amt == 8'(W)) begin
            res_o   = '0;
            carry_o = val_i[0];
          end else begin
            res_o   = '0;
            carry_o = 1'b0;
          end
        end
        K_LSR: begin
          if (!big) begin
            res_o   = val_i >> lo;
            carry_o = val_i[lo_dec];
          end else begin
            res_o   = '0;
            carry_o = val_i[W-1];
          end
        end
        K_ASR: begin
          if (!big) begin
            res_o   = W'($signed(val_i) >>> lo);
            carry_o = val_i[lo_dec];
          end else begin
            res_o   = {W{val_i[W-1]}};
            carry_o = val_i[W-1];
          end
        end
        K_ROR: begin
          if (lo != 5'd0) begin
            res_o   = (val_i >> lo) | (val_i << lo_neg);
            carry_o = val_i[lo_dec];
          end else begin
            res_o   = {carry_i, val_i[W-1:1]};
            carry_o = val_i[0];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({field_i, val_i, reg_amt_i, carry_i})) begin
      // R1
      illegal_imm_chk: assert (field_i[0] || !illegal_o);
      // R2
      reg_zero_pass_chk: assert (!(by_reg && reg_amt_i == 8'd0) ||
                                 (res_o == val_i && carry_o == carry_i));
      // R4
      lsl_far_chk: assert (!(field_i[2:1] == 2'd0 && by_reg && reg_amt_i > 8'd32) ||
                           (res_o == '0 && !carry_o));
      // R6
      asr_fill_chk: assert (!(field_i[2:1] == 2'd2 && (!by_reg ? imm == 5'd0 : reg_amt_i >= 8'd32)) ||
                            (res_o == {W{val_i[W-1]}} && carry_o == val_i[W-1]));
      // R8
      rrx_chk: assert (!(field_i[2:1] == 2'd3 && !by_reg && imm == 5'd0) ||
                       (res_o[W-1] == carry_i && carry_o == val_i[0] && res_o[W-2:0] == val_i[W-1:1]));
    end
  end
endmodule

// File: tb/shift_operand_unit_tb.sv
module shift_operand_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic [7:0]  field;
  logic [31:0] val;
  logic [7:0]  ramt;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  logic        ill;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  shift_operand_unit u_dut (
    .field_i(field), .val_i(val), .reg_amt_i(ramt), .carry_i(cin),
    .res_o(res), .carry_o(cout), .illegal_o(ill)
  );

  function automatic logic [33:0] model(input logic [7:0] f, input logic [31:0] v,
                                        input logic [7:0] ra, input logic ci);
    int n;
    logic c;
    logic [31:0] x;
    x = v;
    c = ci;
    n = f[0] ? int'(ra) : int'(f[7:3]);
    if (n == 0 && (f[0] || f[2:1] == 2'd0))
      return {f[0] & f[3], c, x};
    if (n == 0) n = 32;
    case (f[2:1])
      2'd0: for (int i = 0; i < n; i++) begin c = x[31]; x = x << 1; end
      2'd1: for (int i = 0; i < n && i < 32; i++) begin c = x[0]; x = x >> 1; end
      2'd2: for (int i = 0; i < n && i < 32; i++) begin c = x[0]; x = {x[31], x[31:1]}; end
      default: begin
        if (n % 32 == 0) begin
          c = x[0];
          x = {ci, x[31:1]};
        end else
          for (int i = 0; i < n % 32; i++) begin c = x[0]; x = {x[0], x[31:1]}; end
      end
    endcase
    return {f[0] & f[3], c, x};
  endfunction

  function automatic string tag_of(input logic [7:0] f, input logic [7:0] ra);
    int n;
    n = f[0] ? int'(ra) : int'(f[7:3]);
    if (f[0] && n == 0) return "R2";
    if (!f[0] && n == 0 && f[2:1] == 2'd0) return "R3";
    case (f[2:1])
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return ((n % 32) == 0) ? "R8" : "R7";
    endcase
  endfunction

  task automatic apply(input logic [7:0] f, input logic [31:0] v, input logic [7:0] ra,
                       input logic ci, input string tag);
    logic [33:0] exp;
    field = f; val = v; ramt = ra; cin = ci;
    #(CLK_P/2);
    exp = model(f, v, ra, ci);
    checks++;
    if ({ill, cout, res} !== exp) begin
      errors++;
      $display("FAIL %s field=%h val=%h amt=%h cin=%b: got ill=%b c=%b res=%h exp ill=%b c=%b res=%h",
               tag, f, v, ra, ci, ill, cout, res, exp[33], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd5417));
    field = 8'h00; val = 32'h0; ramt = 8'h0; cin = 1'b0;
    // reset state: immediate LSL #0 of zero
    apply(8'h00, 32'h0, 8'h00, 1'b0, "R3");
    // R1 illegal flag in register mode with bit 7 set
    apply(8'b0000_1001, 32'h8000_0001, 8'd4, 1'b0, "R1");
    apply(8'b0000_1000, 32'h8000_0001, 8'd4, 1'b1, "R1");
    // R3 immediate LSL #0 keeps carry
    apply(8'h00, 32'hDEAD_BEEF, 8'h55, 1'b1, "R3");
    // R4 LSL 32 and 33 by register
    apply(8'b0000_0001, 32'h0000_0001, 8'd32, 1'b0, "R4");
    apply(8'b0000_0001, 32'hFFFF_FFFF, 8'd33, 1'b1, "R4");
    // R5 immediate LSR #0 means 32
    apply(8'b0000_0010, 32'h8000_0000, 8'd0, 1'b0, "R5");
    // R6 ASR of negative by 200
    apply(8'b0000_0101, 32'h8000_0000, 8'd200, 1'b0, "R6");
    // R7 rotate by 4
    apply(8'b0010_0110, 32'h1234_5678, 8'd0, 1'b0, "R7");
    // R8 rotate-through-carry, immediate and register 64
    apply(8'b0000_0110, 32'h0000_0003, 8'd0, 1'b1, "R8");
    apply(8'b0000_0111, 32'h0000_0002, 8'd64, 1'b1, "R8");
    // R2 register amount 0 on every kind
    for (int k = 0; k < 4; k++)
      apply({4'h3, 1'b0, 2'(k), 1'b1}, $urandom, 8'd0, 1'b1, "R2");

    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++) begin
        logic [7:0] f;
        f = {4'($urandom), 1'b0, 2'(k), 1'b1};
        apply(f, $urandom, 8'(a), 1'($urandom), tag_of(f, 8'(a)));
        f[3] = 1'b1;
        apply(f, $urandom, 8'(a), 1'($urandom), tag_of(f, 8'(a)));
      end

    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int r = 0; r < 3; r++) begin
          logic [7:0] f;
          f = {5'(a), 2'(k), 1'b0};
          apply(f, $urandom, 8'($urandom), 1'($urandom), tag_of(f, 8'h0));
        end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule